// File: doc/BRIEF.md
# CAN Node Fault Confinement Controller

This block keeps the error bookkeeping of one CAN node and turns it into the node's standing on the bus. It holds a transmit error counter and a receive error counter, and it moves the node between three standings: active, passive and off the bus. The frame engine next to it sends single-cycle pulses for transmit errors, receive errors, successful transmissions and successful receptions, plus a strobe for each sampled bit with a flag that says whether that bit was recessive.

From the counters the block derives four things. The first is the standing as a two-bit code. The second is whether an error flag must be driven dominant or left recessive. The third is whether the node may transmit. The fourth is whether it may acknowledge. A passive node that has just transmitted is held back for a fixed number of bit times. A node that is off the bus stays there until it has seen 128 runs of 11 recessive bits. It then starts again with clean counters. Every event is registered, so its effect appears at the outputs one clock after the pulse.

Top module: `can_fault_guard`

## Requirements
- R1: With both counters below 128 the state output is 0 (active), flag_dominant is 1, and tx_enable and ack_enable are 1 unless a suspend period runs.
- R2: With either counter at 128 or more and the transmit counter below 256, the state output is 1 (passive) and flag_dominant is 0.
- R3: When the transmit counter reaches 256, the state output is 2 (off the bus). The transmit counter then reads 256, and tx_enable, ack_enable and flag_dominant are all 0.
- R4: A transmit error pulse raises the transmit counter by 8, clamped at 256. A successful transmit pulse lowers it by 1 and never below 0. When both arrive in the same cycle, the error is applied.
- R5: A receive error pulse raises the receive counter by 1, saturating at 255. A successful receive pulse lowers it by 1 and never below 0.
- R6: While off the bus, all four event pulses leave both counters unchanged.
- R7: While off the bus, the 1408th recessive bit strobe that completes the 128th run of 11 consecutive recessive strobes clears both counters. The state output is 0 one clock later.
- R8: A dominant bit strobe while off the bus restarts only the current run of recessive strobes. Runs already completed still count toward the 128.
- R9: A transmit error or successful transmit pulse taken while passive, and not leading off the bus, raises suspend for the next 8 bit strobes. While suspend is high, tx_enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err | input | 1 | Pulse: error seen while transmitting |
| tx_ok | input | 1 | Pulse: frame transmitted successfully |
| rx_err | input | 1 | Pulse: error seen while receiving |
| rx_ok | input | 1 | Pulse: frame received successfully |
| bit_valid | input | 1 | Strobe: one bus bit sampled |
| bit_recessive | input | 1 | Sampled bit was recessive (valid with bit_valid) |
| state | output | 2 | 0 active, 1 passive, 2 off the bus |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| tx_enable | output | 1 | Node may start a transmission |
| ack_enable | output | 1 | Node may drive the acknowledge slot |
| flag_dominant | output | 1 | Error flag is dominant (1) or recessive (0) |
| suspend | output | 1 | Post-transmit wait of a passive node is running |

## Verification
The hardest situation to reach is the exit from the off-bus state when a dominant bit arrives late in recovery. The node must first be driven to a transmit count of 256, and then fed well over a thousand bit strobes with a dominant bit placed one bit short of the final run. The bench does this: it sweeps the transmit error counter from zero up to the off-bus limit, feeds 127 complete recessive runs plus ten more strobes, inserts one dominant strobe, and shows that exactly eleven further recessive strobes, not a full new count, bring the node back. A running arithmetic model of both counters, the suspend window and the run counts gives the expected value after every single pulse.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters #(
    parameter int TX_INC     = 8,
    parameter int RX_INC     = 1,
    parameter int BUSOFF_LIM = 256,
    parameter int TEC_W      = 9,
    parameter int REC_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clear,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             rx_err,
    input  logic             rx_ok,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec
);
    localparam logic [TEC_W:0]   TX_STEP  = (TEC_W+1)'(TX_INC);
    localparam logic [TEC_W:0]   TEC_TOP  = (TEC_W+1)'(BUSOFF_LIM);
    localparam logic [REC_W:0]   RX_STEP  = (REC_W+1)'(RX_INC);
    localparam logic [REC_W:0]   REC_TOP  = (REC_W+1)'((1 << REC_W) - 1);

    typedef struct packed {
        logic [TEC_W-1:0] tec;
        logic [REC_W-1:0] rec;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [TEC_W:0] tx_sum;
    logic [REC_W:0] rx_sum;

    always_comb begin
        cnt_d  = cnt_q;
        tx_sum = {1'b0, cnt_q.tec} + TX_STEP;
        rx_sum = {1'b0, cnt_q.rec} + RX_STEP;
        if (clear) begin
            cnt_d = '0;
        end else if (!hold) begin
            if (tx_err) begin
                cnt_d.tec = (tx_sum >= TEC_TOP) ? TEC_TOP[TEC_W-1:0] : tx_sum[TEC_W-1:0];
            end else if (tx_ok && cnt_q.tec != '0) begin
                cnt_d.tec = cnt_q.tec - TEC_W'(1);
            end
            if (rx_err) begin
                cnt_d.rec = (rx_sum > REC_TOP) ? REC_TOP[REC_W-1:0] : rx_sum[REC_W-1:0];
            end else if (rx_ok && cnt_q.rec != '0) begin
                cnt_d.rec = cnt_q.rec - REC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tec = cnt_q.tec;
    assign rec = cnt_q.rec;
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_TOTAL = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_valid,
    input  logic bit_recessive,
    output logic done
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int SEQ_W = $clog2(RUN_TOTAL + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [SEQ_W-1:0] seq;
    } rcv_t;

    rcv_t rcv_d, rcv_q;

    always_comb begin
        rcv_d = rcv_q;
        done  = 1'b0;
        if (!enable) begin
            rcv_d = '0;
        end else if (bit_valid) begin
            if (!bit_recessive) begin
                rcv_d.run = '0;
            end else if (rcv_q.run == RUN_W'(RUN_LEN - 1)) begin
                rcv_d.run = '0;
                if (rcv_q.seq == SEQ_W'(RUN_TOTAL - 1)) begin
                    rcv_d.seq = '0;
                    done      = 1'b1;
                end else begin
                    rcv_d.seq = rcv_q.seq + SEQ_W'(1);
                end
            end else begin
                rcv_d.run = rcv_q.run + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rcv_q <= '0;
        else        rcv_q <= rcv_d;
    end
endmodule

// File: rtl/can_fc_suspend.sv
module can_fc_suspend #(
    parameter int SUSPEND_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    input  logic bit_valid,
    output logic busy
);
    localparam int SUS_W = $clog2(SUSPEND_BITS + 1);

    logic [SUS_W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (clear) begin
            left_d = '0;
        end else if (load) begin
            left_d = SUS_W'(SUSPEND_BITS);
        end else if (bit_valid && left_q != '0) begin
            left_d = left_q - SUS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard
    import can_fc_pkg::*;
#(
    parameter int TX_INC       = 8,
    parameter int RX_INC       = 1,
    parameter int PASSIVE_LIM  = 128,
    parameter int BUSOFF_LIM   = 256,
    parameter int RUN_LEN      = 11,
    parameter int RUN_TOTAL    = 128,
    parameter int SUSPEND_BITS = 8,
    localparam int TEC_W       = $clog2(BUSOFF_LIM) + 1,
    localparam int REC_W       = $clog2(BUSOFF_LIM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             bit_valid,
    input  logic             bit_recessive,
    output logic [1:0]       state,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic             tx_enable,
    output logic             ack_enable,
    output logic             flag_dominant,
    output logic             suspend
);
    fc_state_e cur_state;
    logic      off_bus;
    logic      recovered;
    logic      wait_busy;
    logic      tx_event;

    can_fc_counters #(
        .TX_INC(TX_INC), .RX_INC(RX_INC), .BUSOFF_LIM(BUSOFF_LIM),
        .TEC_W(TEC_W), .REC_W(REC_W)
    ) u_counters (
        .clk(clk), .rst_n(rst_n), .hold(off_bus), .clear(recovered),
        .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err), .rx_ok(rx_ok),
        .tec(tec), .rec(rec)
    );

    can_fc_recovery #(
        .RUN_LEN(RUN_LEN), .RUN_TOTAL(RUN_TOTAL)
    ) u_recovery (
        .clk(clk), .rst_n(rst_n), .enable(off_bus),
        .bit_valid(bit_valid), .bit_recessive(bit_recessive), .done(recovered)
    );

    can_fc_suspend #(
        .SUSPEND_BITS(SUSPEND_BITS)
    ) u_suspend (
        .clk(clk), .rst_n(rst_n), .clear(off_bus),
        .load(tx_event && cur_state == FC_PASSIVE),
        .bit_valid(bit_valid), .busy(wait_busy)
    );

    always_comb begin
        off_bus  = (tec >= TEC_W'(BUSOFF_LIM));
        tx_event = tx_err || tx_ok;
        if (off_bus)
            cur_state = FC_BUSOFF;
        else if (tec >= TEC_W'(PASSIVE_LIM) || rec >= REC_W'(PASSIVE_LIM))
            cur_state = FC_PASSIVE;
        else
            cur_state = FC_ACTIVE;
    end

    assign state         = cur_state;
    assign suspend       = wait_busy && !off_bus;
    assign tx_enable     = !off_bus && !suspend;
    assign ack_enable    = !off_bus;
    assign flag_dominant = (cur_state == FC_ACTIVE);
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
    parameter int TX_INC     = 8,
    parameter int BUSOFF_LIM = 256,
    parameter int TEC_W      = 9,
    parameter int REC_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err,
    input logic             rx_err,
    input logic             rx_ok,
    input logic             bit_valid,
    input logic [1:0]       state,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic             tx_enable,
    input logic             ack_enable,
    input logic             suspend
);
    a_r3_silent_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        state == 2'd2 |-> (!tx_enable && !ack_enable));

    a_r3_tec_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        tec <= TEC_W'(BUSOFF_LIM));

    a_r4_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd2 && tx_err && tec < TEC_W'(BUSOFF_LIM - TX_INC))
        |=> tec == $past(tec) + TEC_W'(TX_INC));

    a_r5_rec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd2 && !rx_err && !rx_ok) |=> $stable(rec));

    a_r6_frozen_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && !bit_valid) |=> ($stable(tec) && $stable(rec)));

    a_r7_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == 2'd2 && state != 2'd2) |-> (tec == '0 && rec == '0));

    a_r9_suspend_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend) |-> $past(state) == 2'd1);
endmodule

bind can_fault_guard can_fc_checker #(
    .TX_INC(TX_INC), .BUSOFF_LIM(BUSOFF_LIM), .TEC_W(TEC_W), .REC_W(REC_W)
) u_fc_checker (.*);

// File: tb/tb_can_fault_guard.sv
module tb_can_fault_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 1'b0, tx_ok = 1'b0, rx_err = 1'b0, rx_ok = 1'b0;
    logic bit_valid = 1'b0, bit_recessive = 1'b0;
    logic [1:0] state;
    logic [8:0] tec;
    logic [7:0] rec;
    logic tx_enable, ack_enable, flag_dominant, suspend;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int m_tec = 0, m_rec = 0, m_susp = 0, m_run = 0, m_seq = 0;

    can_fault_guard dut (.*);

    always #10 clk = ~clk;

    task automatic model(input bit te, to, re, ro, bv, br);
        bit was_passive;
        if (m_tec >= 256) begin
            if (bv && br) begin
                m_run++;
                if (m_run == 11) begin
                    m_run = 0;
                    m_seq++;
                    if (m_seq == 128) begin
                        m_seq = 0; m_tec = 0; m_rec = 0;
                    end
                end
            end else if (bv) begin
                m_run = 0;
            end
            m_susp = 0;
        end else begin
            was_passive = (m_tec >= 128 || m_rec >= 128);
            if (te) m_tec = (m_tec + 8 > 256) ? 256 : m_tec + 8;
            else if (to && m_tec > 0) m_tec--;
            if (re) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
            else if (ro && m_rec > 0) m_rec--;
            if (m_tec >= 256) m_susp = 0;
            else if (was_passive && (te || to)) m_susp = 8;
            else if (bv && m_susp > 0) m_susp--;
        end
    endtask

    task automatic chk(input string tag);
        int es;
        bit etx, eack, eflag, esus;
        es    = (m_tec >= 256) ? 2 : ((m_tec >= 128 || m_rec >= 128) ? 1 : 0);
        esus  = (m_susp != 0);
        etx   = (es != 2) && !esus;
        eack  = (es != 2);
        eflag = (es == 0);
        n_checks++;
        if (state != 2'(es) || tec != 9'(m_tec) || rec != 8'(m_rec) || tx_enable != etx ||
            ack_enable != eack || flag_dominant != eflag || suspend != esus) begin
            n_fail++;
            $display("FAIL %s: state=%0d tec=%0d rec=%0d txen=%0d ack=%0d flag=%0d susp=%0d expected state=%0d tec=%0d rec=%0d txen=%0d ack=%0d flag=%0d susp=%0d",
                     tag, state, tec, rec, tx_enable, ack_enable, flag_dominant, suspend,
                     es, m_tec, m_rec, etx, eack, eflag, esus);
        end
    endtask

    task automatic ev(input bit te, to, re, ro, bv, br, input string tag);
        tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
        bit_valid = bv; bit_recessive = br;
        model(te, to, re, ro, bv, br);
        @(negedge clk);
        tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; bit_valid = 0; bit_recessive = 0;
        chk(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset");

        // R5 and R2: receive errors up to and past saturation
        for (int i = 0; i < 260; i++) ev(0, 0, 1, 0, 0, 0, "R5/R2 rx_err sweep");
        // R5 and R1: successful receptions down to the floor
        for (int i = 0; i < 270; i++) ev(0, 0, 0, 1, 0, 0, "R5/R1 rx_ok sweep");
        // R4: successful transmit at zero stays at zero
        ev(0, 1, 0, 0, 0, 0, "R4 tx_ok floor");

        // R9: passive through receive counter, then transmit
        for (int i = 0; i < 128; i++) ev(0, 0, 1, 0, 0, 0, "R2 rx to passive");
        ev(0, 1, 0, 0, 0, 0, "R9 suspend start");
        for (int i = 0; i < 8; i++) ev(0, 0, 0, 0, 1, 1, "R9 suspend countdown");
        ev(0, 0, 0, 1, 0, 0, "R1 back to active");
        // R4: simultaneous error and success, error applies
        ev(1, 1, 0, 0, 0, 0, "R4 err wins over ok");

        // R4, R2, R3: transmit error sweep to off-bus
        for (int i = 0; i < 31; i++) ev(1, 0, 0, 0, 0, 0, "R4/R3 tx_err sweep");

        // R6: events ignored while off the bus
        ev(1, 0, 0, 0, 0, 0, "R6 tx_err ignored");
        ev(0, 1, 0, 0, 0, 0, "R6 tx_ok ignored");
        ev(0, 0, 1, 0, 0, 0, "R6 rx_err ignored");
        ev(0, 0, 0, 1, 0, 0, "R6 rx_ok ignored");

        // R7, R8: recovery with a late dominant bit
        for (int i = 0; i < 127 * 11; i++) ev(0, 0, 0, 0, 1, 1, "R7 recovery runs");
        for (int i = 0; i < 10; i++) ev(0, 0, 0, 0, 1, 1, "R8 partial run");
        ev(0, 0, 0, 0, 1, 0, "R8 dominant restart");
        for (int i = 0; i < 10; i++) ev(0, 0, 0, 0, 1, 1, "R8 still off bus");
        ev(0, 0, 0, 0, 1, 1, "R7 recovered");

        // R4, R2, R1: passive by transmit counter and back down
        for (int i = 0; i < 17; i++) ev(1, 0, 0, 0, 0, 0, "R4/R2 tx to passive");
        for (int i = 0; i < 9; i++) ev(0, 1, 0, 0, 0, 0, "R4/R1 tx_ok recovery");
        for (int i = 0; i < 8; i++) ev(0, 0, 0, 0, 1, 0, "R9 suspend drains");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule